// File: doc/BRIEF.md
# Integer Execute Stage with Bit-Serial Shifter

This block is the execute stage of a small 32-bit integer core. It receives decoded control fields together with the two register values, the program counter, the immediate, the load data and a counter value. It then picks the two ALU inputs and runs the integer operation. It produces three things: the writeback value, the next program counter, and a wait request.

A control line can force the ALU to add, whatever the operation field holds. This lets one adder compute load and store addresses, upper-immediate results and jump and branch targets. Shifts move the operand one bit per clock. Every other operation completes in the cycle it is presented.

Instructions arrive with `issue_valid`. The stage answers with `wait_req`, which acts as an inverted ready. While `wait_req` is high, the upstream stage must hold every input stable. An instruction is accepted, and its results are valid, in the cycle where `res_valid` is high. Only `issue_valid` together with a shift operation can raise `wait_req`.

Top module: `rvx_exec_stage`

## Requirements
- R1: Operand A is `rs1_val` when `src1_pc`=0 and `pc` when `src1_pc`=1. Operand B is `rs2_val` when `src2_imm`=0 and `imm` when `src2_imm`=1.
- R2: With `op_sel`=0 the ALU returns A+B and ignores `funct3` and `qual`. This includes the shift codes, which then raise no wait.
- R3: With `op_sel`=1, `funct3` selects the operation, and each of these results appears in the issue cycle with `res_valid`=1:
  - 000: add, or subtract when `qual`=1
  - 010: signed less-than, giving 1 or 0 zero-extended
  - 011: unsigned less-than, giving 1 or 0 zero-extended
  - 100: xor
  - 110: or
  - 111: and
- R4: With `op_sel`=1, `funct3`=001 shifts A left and `funct3`=101 shifts A right. The right shift is logical when `qual`=0 and arithmetic when `qual`=1. The shift amount is B[4:0]. `wait_req` stays high from the issue cycle for amount+1 cycles, and then the result is shown with `res_valid`=1.
- R5: A shift by zero holds `wait_req` for exactly one cycle and returns A unchanged.
- R6: `wb_value` follows the one-hot `wb_sel`:
  - 0001: ALU result
  - 0010: `pc`+4
  - 0100: `load_data`
  - 1000: `counter_val`
- R7: `next_pc` follows the one-hot `pc_sel`:
  - 001: `pc`+4
  - 010: ALU result
  - 100: ALU result when `branch_taken`=1, and `pc`+4 otherwise
- R8: `branch_taken` compares `rs1_val` with `rs2_val` according to `funct3`, and is 0 for 010 and 011:
  - 000: equal
  - 001: not equal
  - 100: signed less-than
  - 101: signed greater-or-equal
  - 110: unsigned less-than
  - 111: unsigned greater-or-equal
- R9: Whenever `next_pc` takes the ALU result, bit 0 of `next_pc` is 0.
- R10: A synchronous active-high `rst` aborts any shift in progress. After reset, `wait_req` is 0, and the next shift takes its full amount+1 wait cycles.
- R11: `res_valid` is 1 exactly when `issue_valid` is 1 and `wait_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented |
| op_sel | input | 1 | 0 forces add, 1 uses funct3/qual |
| src1_pc | input | 1 | Operand A select (0 rs1, 1 pc) |
| src2_imm | input | 1 | Operand B select (0 rs2, 1 imm) |
| funct3 | input | 3 | Operation / branch condition code |
| qual | input | 1 | Subtract / arithmetic-shift qualifier |
| wb_sel | input | 4 | One-hot writeback select |
| pc_sel | input | 3 | One-hot next-PC select |
| rs1_val | input | 32 | First register value |
| rs2_val | input | 32 | Second register value |
| pc | input | 32 | Current program counter |
| imm | input | 32 | Decoded immediate |
| load_data | input | 32 | Data returned by a load |
| counter_val | input | 32 | Counter value for writeback |
| alu_result | output | 32 | ALU or shifter result |
| wb_value | output | 32 | Selected writeback value |
| next_pc | output | 32 | Selected next program counter |
| branch_taken | output | 1 | Branch predicate |
| wait_req | output | 1 | Stage busy; hold inputs |
| res_valid | output | 1 | Results valid, instruction accepted |

## Verification
The add, logic, compare, writeback, next-PC and branch results are combinational. The bench therefore drives inputs on a falling edge and samples one time unit later, in the same cycle. A shift result is due amount+1 cycles after the issue cycle. The bench counts the falling edges on which `wait_req` is still high and requires that count to equal amount+1 before it compares the result. After a reset during a shift, the bench starts a short shift and checks that it takes its full count of cycles.

// File: rtl/rvx_pkg.sv
package rvx_pkg;
  localparam int XLEN = 32;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_SLL  = 3'b001;
  localparam logic [2:0] F3_SLT  = 3'b010;
  localparam logic [2:0] F3_SLTU = 3'b011;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_SR   = 3'b101;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_AND  = 3'b111;

  // branch condition codes share the funct3 field
  localparam logic [2:0] BR_EQ  = 3'b000;
  localparam logic [2:0] BR_NE  = 3'b001;
  localparam logic [2:0] BR_LT  = 3'b100;
  localparam logic [2:0] BR_GE  = 3'b101;
  localparam logic [2:0] BR_LTU = 3'b110;
  localparam logic [2:0] BR_GEU = 3'b111;

  // bit positions inside the one-hot selects
  localparam int WB_ALU = 0;
  localparam int WB_PC4 = 1;
  localparam int WB_MEM = 2;
  localparam int WB_CNT = 3;
  localparam int WB_N   = 4;

  localparam int NP_PC4  = 0;
  localparam int NP_ALU  = 1;
  localparam int NP_COND = 2;
  localparam int NP_N    = 3;
endpackage

// File: rtl/rvx_alu.sv
module rvx_alu
  import rvx_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         op_sel,
  input  logic [2:0]   funct3,
  input  logic         qual,
  output logic [W-1:0] result
);
  logic         sub;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         lt_s;
  logic         lt_u;

  always_comb begin
    sub    = op_sel & qual & (funct3 == F3_ADD);
    b_eff  = sub ? ~b : b;
    sum    = a + b_eff + {{(W-1){1'b0}}, sub};
    lt_s   = $signed(a) < $signed(b);
    lt_u   = a < b;
    result = sum;
    if (op_sel) begin
      case (funct3)
        F3_ADD:  result = sum;
        F3_SLT:  result = {{(W-1){1'b0}}, lt_s};
        F3_SLTU: result = {{(W-1){1'b0}}, lt_u};
        F3_XOR:  result = a ^ b;
        F3_OR:   result = a | b;
        F3_AND:  result = a & b;
        default: result = '0; // shift codes are served by the shifter
      endcase
    end
  end
endmodule

// File: rtl/rvx_shifter.sv
module rvx_shifter #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           left,
  input  logic           arith,
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic           busy,
  output logic           done,
  output logic [SHW-1:0] cnt,
  output logic [W-1:0]   dout
);
  logic         dir_left;
  logic         fill_sign;
  logic [W-1:0] step;

  always_comb begin
    if (dir_left) step = {dout[W-2:0], 1'b0};
    else          step = {fill_sign & dout[W-1], dout[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      dout      <= '0;
      dir_left  <= 1'b0;
      fill_sign <= 1'b0;
    end else if (start && !busy) begin
      busy      <= 1'b1;
      cnt       <= amt;
      dout      <= din;
      dir_left  <= left;
      fill_sign <= arith;
    end else if (busy) begin
      if (cnt != '0) begin
        dout <= step;
        cnt  <= cnt - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/rvx_branch.sv
module rvx_branch
  import rvx_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [2:0]   cond,
  output logic         taken
);
  always_comb begin
    case (cond)
      BR_EQ:   taken = (x == y);
      BR_NE:   taken = (x != y);
      BR_LT:   taken = $signed(x) <  $signed(y);
      BR_GE:   taken = $signed(x) >= $signed(y);
      BR_LTU:  taken = x <  y;
      BR_GEU:  taken = x >= y;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/rvx_onehot_mux.sv
module rvx_onehot_mux #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] din,
  output logic [W-1:0]   dout
);
  logic [W-1:0] term [N];

  for (genvar i = 0; i < N; i++) begin : g_term
    assign term[i] = din[i*W +: W] & {W{sel[i]}};
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) dout = dout | term[i];
  end
endmodule

// File: rtl/rvx_exec_stage.sv
module rvx_exec_stage
  import rvx_pkg::*;
#(
  parameter int W = XLEN,
  localparam int SHW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic          op_sel,
  input  logic          src1_pc,
  input  logic          src2_imm,
  input  logic [2:0]    funct3,
  input  logic          qual,
  input  logic [WB_N-1:0] wb_sel,
  input  logic [NP_N-1:0] pc_sel,
  input  logic [W-1:0]  rs1_val,
  input  logic [W-1:0]  rs2_val,
  input  logic [W-1:0]  pc,
  input  logic [W-1:0]  imm,
  input  logic [W-1:0]  load_data,
  input  logic [W-1:0]  counter_val,
  output logic [W-1:0]  alu_result,
  output logic [W-1:0]  wb_value,
  output logic [W-1:0]  next_pc,
  output logic          branch_taken,
  output logic          wait_req,
  output logic          res_valid
);
  localparam logic [W-1:0] PC_STEP = W'(4);

  logic [W-1:0]   op_a;
  logic [W-1:0]   op_b;
  logic [W-1:0]   core_res;
  logic           is_shift;
  logic           shf_start;
  logic           shf_busy;
  logic           shf_done;
  logic [SHW-1:0] shf_cnt;
  logic [W-1:0]   shf_res;
  logic [W-1:0]   pc_plus4;
  logic [W-1:0]   jump_tgt;
  logic [W-1:0]   cond_tgt;

  assign op_a = src1_pc  ? pc  : rs1_val;
  assign op_b = src2_imm ? imm : rs2_val;

  rvx_alu #(.W(W)) u_alu (
    .a(op_a), .b(op_b), .op_sel(op_sel), .funct3(funct3), .qual(qual),
    .result(core_res)
  );

  assign is_shift  = op_sel && (funct3 == F3_SLL || funct3 == F3_SR);
  assign shf_start = issue_valid && is_shift;

  rvx_shifter #(.W(W)) u_shf (
    .clk(clk), .rst(rst), .start(shf_start),
    .left(funct3 == F3_SLL), .arith(qual),
    .din(op_a), .amt(op_b[SHW-1:0]),
    .busy(shf_busy), .done(shf_done), .cnt(shf_cnt), .dout(shf_res)
  );

  assign wait_req   = shf_start && !shf_done;
  assign res_valid  = issue_valid && !wait_req;
  assign alu_result = is_shift ? shf_res : core_res;

  rvx_branch #(.W(W)) u_br (
    .x(rs1_val), .y(rs2_val), .cond(funct3), .taken(branch_taken)
  );

  assign pc_plus4 = pc + PC_STEP;
  assign jump_tgt = {alu_result[W-1:1], 1'b0};
  assign cond_tgt = branch_taken ? jump_tgt : pc_plus4;

  rvx_onehot_mux #(.N(WB_N), .W(W)) u_wb_mux (
    .sel(wb_sel),
    .din({counter_val, load_data, pc_plus4, alu_result}),
    .dout(wb_value)
  );

  rvx_onehot_mux #(.N(NP_N), .W(W)) u_pc_mux (
    .sel(pc_sel),
    .din({cond_tgt, jump_tgt, pc_plus4}),
    .dout(next_pc)
  );
endmodule

// File: rtl/rvx_exec_stage_chk.sv
module rvx_exec_stage_chk #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input logic           clk,
  input logic           rst,
  input logic           issue_valid,
  input logic           op_sel,
  input logic [2:0]     pc_sel,
  input logic [W-1:0]   next_pc,
  input logic           wait_req,
  input logic           busy,
  input logic [SHW-1:0] cnt
);
  // R10: reset leaves the shifter idle
  assert_reset_idle_R10: assert property (@(posedge clk) $past(rst) |-> !busy);

  // R4: a wait is only ever raised for a presented instruction
  assert_wait_needs_issue_R4: assert property (@(posedge clk) disable iff (rst)
    wait_req |-> issue_valid);

  // R4: one bit per clock while the count is non-zero
  assert_count_steps_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  // R4: completion releases the shifter on the next edge
  assert_done_releases_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == '0) |=> !busy);

  // R2: forced add never waits
  assert_add_no_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !op_sel) |-> !wait_req);

  // R9: jump targets are even
  assert_jump_even_R9: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 3'b010) |-> !next_pc[0]);
endmodule

bind rvx_exec_stage rvx_exec_stage_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .op_sel(op_sel),
  .pc_sel(pc_sel), .next_pc(next_pc), .wait_req(wait_req),
  .busy(shf_busy), .cnt(shf_cnt)
);

// File: tb/rvx_exec_stage_test.sv
module rvx_exec_stage_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0, op_sel = 1'b0, src1_pc = 1'b0, src2_imm = 1'b0, qual = 1'b0;
  logic [2:0]  funct3 = '0;
  logic [3:0]  wb_sel = 4'b0001;
  logic [2:0]  pc_sel = 3'b001;
  logic [31:0] rs1_val = '0, rs2_val = '0, pc = '0, imm = '0, load_data = '0, counter_val = '0;
  logic [31:0] alu_result, wb_value, next_pc;
  logic        branch_taken, wait_req, res_valid;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  rvx_exec_stage uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .op_sel(op_sel),
    .src1_pc(src1_pc), .src2_imm(src2_imm), .funct3(funct3), .qual(qual),
    .wb_sel(wb_sel), .pc_sel(pc_sel), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .pc(pc), .imm(imm), .load_data(load_data), .counter_val(counter_val),
    .alu_result(alu_result), .wb_value(wb_value), .next_pc(next_pc),
    .branch_taken(branch_taken), .wait_req(wait_req), .res_valid(res_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic present(logic os, logic s1, logic s2, logic [2:0] f3, logic q,
                         logic [31:0] r1, logic [31:0] r2, logic [31:0] p, logic [31:0] im);
    @(negedge clk);
    issue_valid = 1'b1; op_sel = os; src1_pc = s1; src2_imm = s2; funct3 = f3; qual = q;
    rs1_val = r1; rs2_val = r2; pc = p; imm = im;
    #1;
  endtask

  task automatic t_reset();
    chk("R10 wait after reset", {31'b0, wait_req}, 32'd0);
    chk("R11 valid idle", {31'b0, res_valid}, 32'd0);
  endtask

  task automatic t_operands();
    present(0, 0, 0, 3'b000, 0, 32'd100, 32'd23, 32'h1000, 32'd7);
    chk("R1 rs1+rs2", alu_result, 32'd123);
    present(0, 1, 1, 3'b000, 0, 32'd100, 32'd23, 32'h1000, 32'h0001_2000);
    chk("R1 pc+imm", alu_result, 32'h0001_3000);
    present(0, 0, 1, 3'b000, 0, 32'd0, 32'd23, 32'h1000, 32'hABCD_E000);
    chk("R1 zero+imm", alu_result, 32'hABCD_E000);
    present(0, 1, 0, 3'b000, 0, 32'd5, 32'd9, 32'h40, 32'd0);
    chk("R1 pc+rs2", alu_result, 32'h49);
  endtask

  task automatic t_force_add();
    present(0, 0, 0, 3'b101, 1, 32'd50, 32'd8, 0, 0);
    chk("R2 forced add", alu_result, 32'd58);
    chk("R2 no wait", {31'b0, wait_req}, 32'd0);
    present(0, 0, 0, 3'b000, 1, 32'd50, 32'd8, 0, 0);
    chk("R2 qual ignored", alu_result, 32'd58);
    issue_valid = 1'b0;
  endtask

  task automatic t_alu_ops();
    logic [31:0] a = 32'hF0F0_1234;
    logic [31:0] b = 32'h0FF0_00FF;
    present(1, 0, 0, 3'b000, 1, 32'd10, 32'd25, 0, 0);
    chk("R3 sub", alu_result, 32'hFFFF_FFF1);
    chk("R11 valid", {31'b0, res_valid}, 32'd1);
    present(1, 0, 0, 3'b010, 0, 32'hFFFF_FFFE, 32'd1, 0, 0);
    chk("R3 slt", alu_result, 32'd1);
    present(1, 0, 0, 3'b011, 0, 32'hFFFF_FFFE, 32'd1, 0, 0);
    chk("R3 sltu", alu_result, 32'd0);
    present(1, 0, 0, 3'b100, 0, a, b, 0, 0);
    chk("R3 xor", alu_result, a ^ b);
    present(1, 0, 0, 3'b110, 0, a, b, 0, 0);
    chk("R3 or", alu_result, a | b);
    present(1, 0, 1, 3'b111, 0, a, 32'd0, 0, b);
    chk("R3 and", alu_result, a & b);
    issue_valid = 1'b0;
  endtask

  task automatic t_shift(string req, logic left, logic ar, logic [31:0] a,
                         logic [31:0] b, logic use_imm);
    int n = 0;
    int amt = int'(b[4:0]);
    logic [31:0] exp;
    if (left)    exp = a << amt;
    else if (ar) exp = 32'($signed(a) >>> amt);
    else         exp = a >> amt;
    present(1, 0, use_imm, left ? 3'b001 : 3'b101, ar, a, use_imm ? 32'hDEAD : b, 0,
            use_imm ? b : 32'd0);
    chk({req, " wait at issue"}, {31'b0, wait_req}, 32'd1);
    while (wait_req && n < 40) begin
      @(negedge clk); #1; n++;
    end
    chk({req, " cycles"}, n, amt + 1);
    chk({req, " result"}, alu_result, exp);
    chk({req, " wb"}, wb_value, exp);
    chk("R11 valid at done", {31'b0, res_valid}, 32'd1);
    issue_valid = 1'b0;
  endtask

  task automatic t_reset_mid_shift();
    present(1, 0, 1, 3'b001, 0, 32'h1, 0, 0, 32'd20);
    repeat (3) @(negedge clk);
    rst = 1'b1; issue_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; #1;
    chk("R10 wait cleared", {31'b0, wait_req}, 32'd0);
    t_shift("R10 fresh count", 1, 0, 32'h3, 32'd2, 1);
  endtask

  task automatic t_writeback();
    present(0, 0, 0, 3'b000, 0, 32'd3, 32'd4, 32'h2000, 0);
    load_data = 32'h5555_AAAA; counter_val = 32'h0000_BEEF;
    wb_sel = 4'b0001; #1; chk("R6 alu", wb_value, 32'd7);
    wb_sel = 4'b0010; #1; chk("R6 pc4", wb_value, 32'h2004);
    wb_sel = 4'b0100; #1; chk("R6 load", wb_value, 32'h5555_AAAA);
    wb_sel = 4'b1000; #1; chk("R6 counter", wb_value, 32'h0000_BEEF);
    wb_sel = 4'b0001; issue_valid = 1'b0;
  endtask

  task automatic t_next_pc();
    present(0, 0, 1, 3'b000, 0, 32'h0000_3001, 0, 32'h100, 32'h10);
    pc_sel = 3'b001; #1; chk("R7 pc4", next_pc, 32'h104);
    pc_sel = 3'b010; #1; chk("R9 jalr even", next_pc, 32'h0000_3010);
    present(0, 1, 1, 3'b000, 0, 32'd7, 32'd7, 32'h200, 32'h40);
    pc_sel = 3'b100; #1; chk("R7 taken", next_pc, 32'h240);
    rs2_val = 32'd8; #1; chk("R7 not taken", next_pc, 32'h204);
    pc_sel = 3'b001; issue_valid = 1'b0;
  endtask

  task automatic t_branch();
    logic [31:0] neg = 32'hFFFF_FFF0;
    logic [31:0] pos = 32'd5;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] x, y;
        logic e;
        x = (k == 0) ? neg : pos;
        y = (k == 1) ? neg : pos;
        case (c[2:0])
          3'b000: e = (x == y);
          3'b001: e = (x != y);
          3'b100: e = $signed(x) < $signed(y);
          3'b101: e = !($signed(x) < $signed(y));
          3'b110: e = x < y;
          3'b111: e = !(x < y);
          default: e = 1'b0;
        endcase
        present(0, 1, 1, c[2:0], 0, x, y, 0, 0);
        chk("R8 predicate", {31'b0, branch_taken}, {31'b0, e});
      end
    end
    issue_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_operands();
    t_force_add();
    t_alu_ops();
    t_shift("R4 sll", 1, 0, 32'h8000_0013, 32'd5, 0);
    t_shift("R4 srl", 0, 0, 32'h8000_0F00, 32'd7, 1);
    t_shift("R4 sra", 0, 1, 32'h8000_0F00, 32'd9, 0);
    t_shift("R4 amt low bits", 1, 0, 32'h0000_0001, 32'h0000_0425, 1);
    t_shift("R5 zero", 0, 1, 32'hCAFE_F00D, 32'd0, 1);
    t_shift("R4 sra 31", 0, 1, 32'h8000_0000, 32'd31, 0);
    t_reset_mid_shift();
    t_writeback();
    t_next_pc();
    t_branch();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule